// File: doc/BRIEF.md
# Byte-Multiplexed Pipelined Output Formatter

This block takes 14-bit conversion results, each with a small channel tag, and puts them on an 8-bit output bus as two bytes per result. The upper eight result bits go out first and the remaining six bits follow, left-justified. A result travels through a fixed three-register pipeline, so every byte leaves a fixed number of converter clocks after its result was presented. The converter holds each result steady for two consecutive advancing clocks, one for each byte.

The bus is released by an active-low output enable, without disturbing the pipeline. A power-down input freezes the whole block: the pipeline, the byte phase and the bus keep their values, and results presented during power-down are dropped. A valid flag stays low after reset until the pipeline has filled, so stale register contents are never marked as data.

Top module: `bytefmt_out`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears: after that edge `byte_valid` is 0, `byte_hi` is 1 (high-byte phase), `byte_tag` is 0 and the driven bus value is 0.
- R2: A high byte carries result bits 13..6 on `bus_data` lines 7..0, and `byte_hi` is 1 for it.
- R3: A low byte carries result bits 5..0 on `bus_data` lines 7..2, with lines 1..0 driven as 0, and `byte_hi` is 0 for it.
- R4: Byte phase alternates on every advancing clock edge, starting with the high byte on the first edge after reset, so each result goes out as high byte then low byte on consecutive cycles.
- R5: The byte on the bus after advancing edge k (counted from reset, k ≥ 3) is taken from the result presented at advancing edge k-2, i.e. three clock edges of delay including the output register.
- R6: While `oe_n` is 1, `bus_drive` is 0 and `bus_data` reads 0; `oe_n` has no effect on the pipeline, so the byte stream continues unchanged once `oe_n` returns to 0.
- R7: While `pwr_dn` is 1, no clock edge changes the outputs or any internal stage, and the result on `code_in`/`tag_in` is ignored; after `pwr_dn` falls the stream resumes where it stopped.
- R8: `byte_valid` rises only after the third advancing edge after reset, it rises on a high byte, and it then stays high until the next reset.
- R9: `byte_tag` shows the channel tag of the result whose byte is on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, flushes the pipeline |
| pwr_dn | input | 1 | Freeze: no advance while high |
| code_in | input | 14 | Conversion result, held for two advancing clocks |
| tag_in | input | 2 | Channel tag of `code_in` |
| oe_n | input | 1 | Active-low output enable |
| bus_data | output | 8 | Byte on the bus; 0 when released |
| bus_drive | output | 1 | 1 when the bus is driven, 0 for high impedance |
| byte_hi | output | 1 | 1 for a high byte, 0 for a low byte |
| byte_tag | output | 2 | Channel tag of the byte on the bus |
| byte_valid | output | 1 | Pipeline filled; bus carries real data |

## Verification
A wrong phase register shows on the very next byte as swapped halves and an inverted `byte_hi`, and a missing or extra pipeline stage shifts every byte by one cycle so that a high byte pairs with the neighbouring result. A fill counter that is off by one flags the cycle before or after the first real high byte, visible at the third edge after reset. A stage that advances during power-down shows as a changed bus on the first frozen cycle and as a lost or repeated byte when the freeze ends.

// File: rtl/bytefmt_pkg.sv
package bytefmt_pkg;

    localparam int CODE_W  = 14;
    localparam int BUS_W   = 8;
    localparam int TAG_W   = 2;
    localparam int LO_BITS = CODE_W - BUS_W;
    localparam int PAD_W   = BUS_W - LO_BITS;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BUS_W-1:0]  bus_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        tag_t  tag;
        code_t code;
    } sample_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        bus_t   data;
        tag_t   tag;
        phase_e ph;
    } byte_t;

    function automatic bus_t pick_byte(sample_t s, phase_e p);
        if (p == PH_HIGH)
            return s.code[CODE_W-1 -: BUS_W];
        return {s.code[LO_BITS-1:0], {PAD_W{1'b0}}};
    endfunction

    function automatic phase_e flip(phase_e p);
        return (p == PH_HIGH) ? PH_LOW : PH_HIGH;
    endfunction

endpackage

// File: rtl/bytefmt_delay.sv
module bytefmt_delay
    import bytefmt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  sample_t din,
    output sample_t dout
);

    sample_t stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)      stg[i] <= '0;
                else if (adv) stg[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)      stg[i] <= '0;
                else if (adv) stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/bytefmt_fill.sv
module bytefmt_fill #(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic valid
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(LATENCY);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    assign valid = (cnt == FULL);

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

endmodule

// File: rtl/bytefmt_serializer.sv
module bytefmt_serializer
    import bytefmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  sample_t src,
    output byte_t   out
);

    phase_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_HIGH;
            out.data <= '0;
            out.tag  <= '0;
            out.ph   <= PH_HIGH;
        end else if (adv) begin
            ph       <= flip(ph);
            out.data <= pick_byte(src, ph);
            out.tag  <= src.tag;
            out.ph   <= ph;
        end
    end

endmodule

// File: rtl/bytefmt_out.sv
module bytefmt_out
    import bytefmt_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic [CODE_W-1:0] code_in,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              oe_n,
    output logic [BUS_W-1:0]  bus_data,
    output logic              bus_drive,
    output logic              byte_hi,
    output logic [TAG_W-1:0]  byte_tag,
    output logic              byte_valid
);

    localparam int STAGES = LATENCY - 1;

    logic    adv;
    sample_t s_in;
    sample_t s_late;
    byte_t   ob;

    assign adv  = !pwr_dn;
    assign s_in = '{tag: tag_in, code: code_in};

    bytefmt_delay #(.DEPTH(STAGES)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .din  (s_in),
        .dout (s_late)
    );

    bytefmt_serializer u_ser (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .src (s_late),
        .out (ob)
    );

    bytefmt_fill #(.LATENCY(LATENCY)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .valid (byte_valid)
    );

    assign bus_drive = !oe_n;
    assign bus_data  = bus_drive ? ob.data : '0;
    assign byte_hi   = (ob.ph == PH_HIGH);
    assign byte_tag  = ob.tag;

    // R4
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !pwr_dn) |=> (byte_hi != $past(byte_hi)));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> ($stable(ob.data) && $stable(byte_hi) && $stable(byte_tag)));

    // R8
    first_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_valid) |-> byte_hi);

    // R3
    low_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_hi) |-> (ob.data[PAD_W-1:0] == '0));

endmodule

// File: tb/bytefmt_out_test.sv
module bytefmt_out_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn = 1'b0;
    logic [13:0] code_in = '0;
    logic [1:0]  tag_in = '0;
    logic        oe_n = 1'b0;
    logic [7:0]  bus_data;
    logic        bus_drive;
    logic        byte_hi;
    logic [1:0]  byte_tag;
    logic        byte_valid;

    int total = 0;
    int bad = 0;
    int k = 0;
    bit done = 1'b0;
    logic [15:0] hist [0:255];

    // {tag[1:0], code[13:0]}
    localparam logic [15:0] VEC [12] = '{
        16'h0000, 16'h7FFF, 16'hAAAA, 16'hD555,
        16'h3FC0, 16'h403F, 16'hA000, 16'h0040,
        16'hD234, 16'h7E01, 16'h8FFF, 16'h2D5B
    };

    always #10 clk = ~clk;

    bytefmt_out uut (
        .clk        (clk),
        .rst        (rst),
        .pwr_dn     (pwr_dn),
        .code_in    (code_in),
        .tag_in     (tag_in),
        .oe_n       (oe_n),
        .bus_data   (bus_data),
        .bus_drive  (bus_drive),
        .byte_hi    (byte_hi),
        .byte_tag   (byte_tag),
        .byte_valid (byte_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (edge %0d)", req, act, exp, k);
        end
    endtask

    task automatic check_outputs();
        logic [15:0] s;
        logic        hi;
        logic [7:0]  b;
        chk("R8 valid", 32'(byte_valid), 32'(k >= 3));
        if (k >= 1) chk("R4 phase", 32'(byte_hi), 32'(k % 2));
        if (oe_n) begin
            chk("R6 drive", 32'(bus_drive), 32'd0);
            chk("R6 data", 32'(bus_data), 32'd0);
        end else begin
            chk("R6 drive", 32'(bus_drive), 32'd1);
        end
        if (k >= 3) begin
            s  = hist[k-2];
            hi = (k % 2) == 1;
            b  = hi ? s[13:6] : {s[5:0], 2'b00};
            if (!oe_n) chk(hi ? "R2/R5 high" : "R3/R5 low", 32'(bus_data), 32'(b));
            chk("R9 tag", 32'(byte_tag), 32'(s[15:14]));
        end
    endtask

    task automatic tick(input logic [15:0] s, input logic p, input logic o);
        code_in = s[13:0];
        tag_in  = s[15:14];
        pwr_dn  = p;
        oe_n    = o;
        @(posedge clk);
        if (!p) begin
            k++;
            hist[k] = s;
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pwr_dn = 1'b0;
        oe_n = 1'b0;
        code_in = 14'h3FFF;
        tag_in = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid", 32'(byte_valid), 32'd0);
        chk("R1 phase", 32'(byte_hi), 32'd1);
        chk("R1 tag", 32'(byte_tag), 32'd0);
        chk("R1 data", 32'(bus_data), 32'd0);
        k = 0;
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: each result held for two advancing edges
        for (int i = 0; i < 12; i++) begin
            tick(VEC[i], 1'b0, 1'b0);
            tick(VEC[i], 1'b0, 1'b0);
        end
        tick(16'h1111, 1'b0, 1'b0);
        tick(16'h1111, 1'b0, 1'b0);

        // R7: freeze mid-stream, inputs changed and must be ignored
        tick(16'h6ABC, 1'b0, 1'b0);
        tick(16'h6ABC, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) tick(16'hFFFF - 16'(i), 1'b1, 1'b0);
        tick(16'h9F0F, 1'b0, 1'b0);
        tick(16'h9F0F, 1'b0, 1'b0);
        // freeze on a low-byte phase
        tick(16'h3003, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) tick(16'h0000, 1'b1, 1'b0);
        tick(16'h3003, 1'b0, 1'b0);
        tick(16'h0000, 1'b0, 1'b0);
        tick(16'h0000, 1'b0, 1'b0);

        // R6: bus released while the stream keeps moving
        tick(16'h5A5A, 1'b0, 1'b1);
        tick(16'h5A5A, 1'b0, 1'b1);
        tick(16'h2468, 1'b0, 1'b1);
        tick(16'h2468, 1'b0, 1'b0);
        tick(16'h0000, 1'b0, 1'b0);
        tick(16'h0000, 1'b0, 1'b0);

        // R1/R8: reset mid-run, fill again from scratch
        do_reset();
        tick(16'hBEEF, 1'b0, 1'b0);
        tick(16'hBEEF, 1'b0, 1'b0);
        tick(16'h4321, 1'b0, 1'b0);
        tick(16'h4321, 1'b0, 1'b0);
        tick(16'h0000, 1'b0, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule